// File: doc/BRIEF.md
# Conversion Start Trigger Selector

This block decides the clock cycle in which an analog-to-digital conversion is started automatically. A select field chooses one of several trigger sources. Code 0 follows the converter's own conversion-complete flag (free-running operation). Every other code follows one peripheral event flag. The chosen source passes through a multiplexer and is sampled once per clock. A rising edge of the sampled value becomes a one-cycle start pulse, provided automatic triggering is enabled, the converter is enabled and no conversion is in progress.

Edges are detected after the multiplexer. Moving the select from a source whose flag is low to one whose flag is high therefore counts as an edge and starts a conversion. The one exception is a move into free-running mode: the edge history is preloaded at that moment, so no start results even if the completion flag is already high. A trigger that arrives while the converter is busy is dropped and is not held for later.

Top module: `adc_trig_sel`

## Requirements
- R1: With `trig_sel` = k, the trigger source is `conv_done` when k = 0 and `periph_flags[k-1]` when k is 1 to 7 (1 comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 1 compare B, 6 timer 1 overflow, 7 timer 1 capture). Flags of unselected sources cause no start.
- R2: Only a 0-to-1 change of the sampled source starts a conversion. A source held high produces one start only.
- R3: `start_o` is high for exactly one cycle. When the source rises before clock edge n, `start_o` is high after edge n+1 and low again after edge n+2.
- R4: While `auto_en` is low, no start is produced whatever the select field or the flags do.
- R5: While `adc_en` is low, no start is produced.
- R6: Changing `trig_sel` from a source whose flag is low to a source whose flag is high produces a start.
- R7: Changing `trig_sel` from a nonzero code to 0 produces no start, even while `conv_done` is high.
- R8: In code 0, each rising edge of `conv_done` produces a start, so the converter retriggers itself on every completion.
- R9: If `busy` is high at the clock edge where the start would be issued, the trigger is discarded and does not appear later.
- R10: A synchronous `rst` clears the edge history and the sampled level. `start_o` and `trig_level` are low after a reset edge.
- R11: `trig_level` shows the selected source as sampled at the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_en | input | 1 | Enables automatic triggering |
| adc_en | input | 1 | Converter enable; a start requires it |
| trig_sel | input | 3 | Trigger source code |
| periph_flags | input | 7 | Peripheral event flags for codes 1 to 7 |
| conv_done | input | 1 | Conversion-complete flag (source for code 0) |
| busy | input | 1 | A conversion is in progress |
| start_o | output | 1 | One-cycle conversion start pulse |
| trig_level | output | 1 | Sampled level of the selected source |

## Verification
The bench builds the block with its default of eight sources, so the 3-bit select is fully used. Every code, including the highest code 7 and the free-running code 0, is reached through the stimulus table. With that width, the move from code 3 to code 0 and from a low to a high peripheral source can both be driven directly, and so can the loss of a trigger on a busy edge.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  // Code reserved for self-retriggering from the completion flag
  localparam int unsigned FREE_CODE = 0;

  // Rising edge between two consecutive samples
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Start qualification: edge seen, both enables on, converter idle
  function automatic logic qualify(input logic edge_seen, input logic auto_on,
                                   input logic conv_on, input logic in_use);
    return edge_seen & auto_on & conv_on & ~in_use;
  endfunction

endpackage

// File: rtl/trig_mux.sv
module trig_mux #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned SLOTS  = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-2:0] flags_i,
  input  logic               done_i,
  output logic               mux_o
);

  logic [SLOTS-1:0] src_vec;

  // Slot 0 carries the completion flag, slots 1.. carry peripheral flags,
  // slots past NUM_SRC are tied low.
  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_slot
      if (gi == 0) begin : g_free
        assign src_vec[gi] = done_i;
      end else if (gi < NUM_SRC) begin : g_periph
        assign src_vec[gi] = flags_i[gi-1];
      end else begin : g_pad
        assign src_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assign mux_o = src_vec[sel_i];

endmodule

// File: rtl/trig_edge.sv
module trig_edge
  import adc_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mux_i,
  output logic             samp_o,
  output logic             edge_o
);

  logic [SEL_W-1:0] sel_q;
  logic             samp_q;
  logic             prev_q;
  logic             enter_free;

  assign enter_free = (sel_i == SEL_W'(FREE_CODE)) && (sel_q != SEL_W'(FREE_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      samp_q <= mux_i;
      // Entering free running preloads history with the new level: no edge
      prev_q <= enter_free ? mux_i : samp_q;
    end
  end

  assign samp_o = samp_q;
  assign edge_o = rise_of(samp_q, prev_q);

  AST_FREE_MASK: assert property (@(posedge clk) disable iff (rst)
    enter_free |=> !edge_o); // R7

  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> $past(mux_i)); // R2

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    samp_o == $past(mux_i) || $past(rst)); // R11

endmodule

// File: rtl/trig_gate.sv
module trig_gate
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  input  logic auto_en_i,
  input  logic adc_en_i,
  input  logic busy_i,
  output logic start_o
);

  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= qualify(edge_i, auto_en_i, adc_en_i, busy_i);
  end

  assign start_o = start_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R3

  AST_AUTO_GATE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(auto_en_i)); // R4

  AST_ADC_GATE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(adc_en_i)); // R5

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(busy_i)); // R9

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               auto_en,
  input  logic               adc_en,
  input  logic [SEL_W-1:0]   trig_sel,
  input  logic [NUM_SRC-2:0] periph_flags,
  input  logic               conv_done,
  input  logic               busy,
  output logic               start_o,
  output logic               trig_level
);

  logic mux_w;   // selected source, combinational
  logic samp_w;  // selected source, sampled
  logic edge_w;  // rising edge of the sampled source

  trig_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .sel_i   (trig_sel),
    .flags_i (periph_flags),
    .done_i  (conv_done),
    .mux_o   (mux_w)
  );

  trig_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (trig_sel),
    .mux_i  (mux_w),
    .samp_o (samp_w),
    .edge_o (edge_w)
  );

  trig_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .edge_i    (edge_w),
    .auto_en_i (auto_en),
    .adc_en_i  (adc_en),
    .busy_i    (busy),
    .start_o   (start_o)
  );

  assign trig_level = samp_w;

  AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(edge_w)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !$past(rst)); // R10

endmodule

// File: tb/sim_adc_trig_sel.sv
module sim_adc_trig_sel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_en = 1'b0;
  logic       adc_en = 1'b0;
  logic [2:0] trig_sel = 3'd0;
  logic [6:0] periph_flags = 7'd0;
  logic       conv_done = 1'b0;
  logic       busy = 1'b0;
  logic       start_o;
  logic       trig_level;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_trig_sel u0 (
    .clk          (clk),
    .rst          (rst),
    .auto_en      (auto_en),
    .adc_en       (adc_en),
    .trig_sel     (trig_sel),
    .periph_flags (periph_flags),
    .conv_done    (conv_done),
    .busy         (busy),
    .start_o      (start_o),
    .trig_level   (trig_level)
  );

  // Vector: {sel[9:7], raised source[6:4], auto[3], adc[2], busy[1], expected start[0]}
  localparam int NV = 12;
  localparam logic [9:0] VECS [NV] = '{
    {3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd2, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd4, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd5, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd6, 3'd6, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd7, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd3, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd2, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd6, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd7, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic raise_src(input logic [2:0] code, input logic val);
    if (code == 3'd0) conv_done = val;
    else periph_flags[code-1] = val;
  endtask

  function automatic string req_of(input logic [9:0] v);
    if (!v[3]) return "R4";
    if (!v[2]) return "R5";
    if (v[1]) return "R9";
    if (v[9:7] != v[6:4]) return "R1";
    return "R3";
  endfunction

  initial begin
    #4_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    // R10: outputs low under reset
    check("R10", start_o, 1'b0, "start in reset");
    check("R10", trig_level, 1'b0, "level in reset");
    rst = 1'b0;
    tick(); tick();

    // Table walk: R1, R3, R4, R5, R9, R11, R8 (code 0 entry)
    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VECS[i];
      periph_flags = '0;
      conv_done = 1'b0;
      trig_sel = v[9:7];
      auto_en = v[3];
      adc_en = v[2];
      busy = v[1];
      tick(); tick();
      raise_src(v[6:4], 1'b1);
      tick();
      check("R11", trig_level, (v[9:7] == v[6:4]), $sformatf("level vec %0d", i));
      tick();
      check((v[9:7] == 3'd0 && v[0]) ? "R8" : req_of(v), start_o, v[0],
            $sformatf("start vec %0d", i));
      tick();
      check("R3", start_o, 1'b0, $sformatf("pulse end vec %0d", i));
      raise_src(v[6:4], 1'b0);
      busy = 1'b0;
      tick();
    end

    auto_en = 1'b1;
    adc_en = 1'b1;
    busy = 1'b0;
    periph_flags = '0;
    conv_done = 1'b0;

    // R2: source held high gives one pulse only
    trig_sel = 3'd4;
    tick(); tick();
    periph_flags[3] = 1'b1;
    tick(); tick();
    check("R2", start_o, 1'b1, "first pulse of held flag");
    begin
      logic extra;
      extra = 1'b0;
      for (int k = 0; k < 5; k++) begin
        tick();
        extra = extra | start_o;
      end
      check("R2", extra, 1'b0, "no repeat while held");
    end
    periph_flags = '0;
    tick();

    // R6: switch from low source to high source
    periph_flags[0] = 1'b1;
    trig_sel = 3'd2;
    tick(); tick();
    check("R6", start_o, 1'b0, "no start on low source");
    trig_sel = 3'd1;
    tick(); tick();
    check("R6", start_o, 1'b1, "start on switch to high source");
    tick();
    periph_flags = '0;

    // R4: select change ignored while auto trigger off
    auto_en = 1'b0;
    periph_flags[4] = 1'b1;
    trig_sel = 3'd3;
    tick(); tick();
    trig_sel = 3'd5;
    tick(); tick();
    check("R4", start_o, 1'b0, "switch with auto off");
    tick();
    periph_flags = '0;
    auto_en = 1'b1;

    // R7: entering free running with completion flag high
    trig_sel = 3'd3;
    conv_done = 1'b1;
    tick(); tick();
    trig_sel = 3'd0;
    tick();
    check("R7", trig_level, 1'b1, "level follows completion flag");
    tick();
    check("R7", start_o, 1'b0, "no start entering free running");
    tick();
    check("R7", start_o, 1'b0, "still no start");

    // R8: free running retriggers on each completion
    conv_done = 1'b0;
    tick();
    conv_done = 1'b1;
    tick(); tick();
    check("R8", start_o, 1'b1, "first completion retrigger");
    conv_done = 1'b0;
    tick();
    conv_done = 1'b1;
    tick(); tick();
    check("R8", start_o, 1'b1, "second completion retrigger");
    conv_done = 1'b0;
    tick();

    // R9: trigger during busy is not queued
    trig_sel = 3'd2;
    tick(); tick();
    busy = 1'b1;
    periph_flags[1] = 1'b1;
    tick(); tick();
    check("R9", start_o, 1'b0, "dropped while busy");
    busy = 1'b0;
    tick();
    check("R9", start_o, 1'b0, "not issued after busy");
    tick();
    check("R9", start_o, 1'b0, "still not issued");
    periph_flags = '0;
    tick();

    // R10: reset mid-activity clears level and suppresses start
    trig_sel = 3'd1;
    tick(); tick();
    periph_flags[0] = 1'b1;
    tick();
    rst = 1'b1;
    tick();
    check("R10", start_o, 1'b0, "start after reset edge");
    check("R10", trig_level, 1'b0, "level after reset edge");
    periph_flags = '0;
    tick();
    rst = 1'b0;
    tick(); tick();
    check("R10", start_o, 1'b0, "quiet after release");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule